// File: doc/BRIEF.md
# Multi-cycle unsigned restoring divider

This block divides an unsigned dividend twice the data width by an unsigned divisor of the data width. It returns a quotient and a remainder, each of the data width. A one-cycle start pulse, taken while the block is idle, captures both operands. The block then spends one clock per quotient bit, beginning with the most significant. Each step moves the next lower dividend bit into the running partial remainder and subtracts the divisor. The sign of that difference is the only test used. A negative difference is undone by adding the divisor back, and the quotient bit is 0. A non-negative difference becomes the new partial remainder, and the quotient bit is 1.

The operands are checked when they are captured. Two cases are rejected at once, with no iteration: a zero divisor, and a quotient too large for the data width. Completion is marked by a one-cycle done pulse. The results and the error flag then stay unchanged until the next accepted start.

Top module: `rdiv_top`

## Requirements
- R1: After reset, busy, done and error are 0, and quotient and remainder are all zeros.
- R2: For a nonzero divisor whose value is greater than the upper half of the dividend, the quotient equals the integer quotient and the remainder equals the integer remainder. With width 4, dividend 147 and divisor 11 give quotient 13 and remainder 4.
- R3: At every completion without error, the remainder is strictly less than the divisor that was captured.
- R4: A zero divisor completes with error = 1, quotient all ones and remainder 0. Done rises after the start edge itself, with no busy cycle.
- R5: A nonzero divisor that is less than or equal to the upper half of the dividend completes the same way as R4: error = 1, quotient all ones, remainder 0, done after the start edge.
- R6: A valid division keeps busy high for exactly N clock edges after the start edge. Done is high in the cycle that follows the Nth edge. Busy and done are never high together.
- R7: Done is high for only one cycle unless a new start arrives in that cycle.
- R8: A start that arrives while busy is ignored. The running division finishes with its original operands.
- R9: While idle and with no start, the quotient, remainder and error outputs stay unchanged.
- R10: A valid division that follows a rejected one clears error to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin a division; taken only when idle |
| dividend_i | input | 2N | Unsigned dividend |
| divisor_i | input | N | Unsigned divisor |
| busy_o | output | 1 | A division is iterating |
| done_o | output | 1 | One-cycle completion pulse |
| quotient_o | output | N | Quotient (all ones on error) |
| remainder_o | output | N | Remainder (0 on error) |
| error_o | output | 1 | The last operation was rejected |

## Verification
The bench runs every dividend and divisor pair of a 4-bit instance. That sweep covers the exact boundary where the upper dividend half equals the divisor. A design that used a strict greater-than there would return a truncated, wrong quotient instead of raising the error. The sweep also reaches divisor 1 and the all-ones divisor, where a partial remainder one bit too narrow loses the carry and gives wrong quotient bits. Zero divisors confirm that no iteration starts, since a design that iterated would report a quotient of all ones with the wrong latency. A start pulse in the middle of a division, with different operands, shows that an unguarded capture would corrupt the result. An idle window after completion shows that the outputs are held.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
  typedef enum logic {PH_IDLE = 1'b0, PH_RUN = 1'b1} rdiv_phase_e;

  // Bits needed to count from 0 up to n inclusive.
  function automatic int cnt_bits(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/rdiv_ctrl.sv
module rdiv_ctrl
  import rdiv_pkg::*;
#(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic reject,
  output logic accept,
  output logic launch,
  output logic step_en,
  output logic last_step,
  output logic busy,
  output logic done
);
  localparam int CW = cnt_bits(N);
  localparam logic [CW-1:0] STEPS = CW'(N);

  rdiv_phase_e   phase_q;
  logic [CW-1:0] left_q;

  assign busy      = (phase_q == PH_RUN);
  assign accept    = start && !busy;
  assign launch    = accept && !reject;
  assign step_en   = busy;
  assign last_step = busy && (left_q == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      left_q  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        phase_q <= PH_RUN;
        left_q  <= STEPS;
      end else if (accept) begin
        done <= 1'b1;
      end else if (busy) begin
        left_q <= left_q - CW'(1);
        if (last_step) begin
          phase_q <= PH_IDLE;
          done    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rdiv_step.sv
module rdiv_step #(
  parameter int N = 8
) (
  input  logic [N-1:0] part_i,
  input  logic [N-1:0] shreg_i,
  input  logic [N-1:0] dvs_i,
  output logic [N-1:0] part_o,
  output logic [N-1:0] shreg_o,
  output logic         neg_o
);
  localparam int PW = N + 1;

  // Trial subtraction on the widened partial remainder; the top bit is the sign.
  function automatic logic [PW-1:0] trial_sub(input logic [PW-1:0] p, input logic [N-1:0] d);
    return p - {1'b0, d};
  endfunction

  // Explicit restore: add the divisor back to a negative trial.
  function automatic logic [PW-1:0] add_back(input logic [PW-1:0] t, input logic [N-1:0] d);
    return t + {1'b0, d};
  endfunction

  logic [PW-1:0] widened;
  logic [PW-1:0] trial;
  logic [PW-1:0] restored;

  always_comb begin
    widened  = {part_i, shreg_i[N-1]};
    trial    = trial_sub(widened, dvs_i);
    neg_o    = trial[PW-1];
    restored = add_back(trial, dvs_i);
    part_o   = neg_o ? restored[N-1:0] : trial[N-1:0];
    shreg_o  = {shreg_i[N-2:0], ~neg_o};
  end
endmodule

// File: rtl/rdiv_top.sv
module rdiv_top #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [2*N-1:0] dividend_i,
  input  logic [N-1:0]   divisor_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [N-1:0]   quotient_o,
  output logic [N-1:0]   remainder_o,
  output logic           error_o
);
  // Rejected when the divisor is zero or the quotient cannot fit in N bits.
  function automatic logic is_rejected(input logic [N-1:0] hi, input logic [N-1:0] d);
    return (d == '0) || (hi >= d);
  endfunction

  logic [N-1:0] part_q, shreg_q, dvs_q;
  logic         err_q;
  logic [N-1:0] part_n, shreg_n;
  logic         trial_neg;
  logic         accept, launch, step_en, last_step, reject;

  assign reject = is_rejected(dividend_i[2*N-1:N], divisor_i);

  rdiv_ctrl #(.N(N)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_i),
    .reject    (reject),
    .accept    (accept),
    .launch    (launch),
    .step_en   (step_en),
    .last_step (last_step),
    .busy      (busy_o),
    .done      (done_o)
  );

  rdiv_step #(.N(N)) step_i (
    .part_i  (part_q),
    .shreg_i (shreg_q),
    .dvs_i   (dvs_q),
    .part_o  (part_n),
    .shreg_o (shreg_n),
    .neg_o   (trial_neg)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      part_q  <= '0;
      shreg_q <= '0;
      dvs_q   <= '0;
      err_q   <= 1'b0;
    end else if (launch) begin
      part_q  <= dividend_i[2*N-1:N];
      shreg_q <= dividend_i[N-1:0];
      dvs_q   <= divisor_i;
      err_q   <= 1'b0;
    end else if (accept) begin
      part_q  <= '0;
      shreg_q <= '1;
      dvs_q   <= divisor_i;
      err_q   <= 1'b1;
    end else if (step_en) begin
      part_q  <= part_n;
      shreg_q <= shreg_n;
    end
  end

  assign quotient_o  = shreg_q;
  assign remainder_o = part_q;
  assign error_o     = err_q;
endmodule

// File: rtl/rdiv_chk.sv
module rdiv_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         busy_o,
  input logic         done_o,
  input logic         error_o,
  input logic [N-1:0] quotient_o,
  input logic [N-1:0] remainder_o,
  input logic [N-1:0] dvs_q
);
  localparam int RW = $clog2(N + 1) + 1;
  logic [RW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) run_cnt <= '0;
    else if (start_i && !busy_o) run_cnt <= '0;
    else if (busy_o) run_cnt <= run_cnt + RW'(1);
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !busy_o && !done_o && !error_o);

  // R3
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !error_o |-> remainder_o < dvs_q);

  // R4
  err_quot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && error_o |-> (quotient_o == '1) && (remainder_o == '0));

  // R6
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(busy_o && done_o));

  // R6
  run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !error_o |-> run_cnt == RW'(N));

  // R6
  fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy_o) |-> done_o);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done_o && !start_i |=> !done_o);

  // R8
  ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i |=> $stable(dvs_q));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !start_i |=> $stable(quotient_o) && $stable(remainder_o) && $stable(error_o));
endmodule

bind rdiv_top rdiv_chk #(.N(N)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .error_o     (error_o),
  .quotient_o  (quotient_o),
  .remainder_o (remainder_o),
  .dvs_q       (dvs_q)
);

// File: tb/rdiv_top_tb_top.sv
module rdiv_top_tb_top;
  localparam int N = 4;
  localparam int CLK_PERIOD = 10;
  localparam int MAXQ = (1 << N) - 1;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [2*N-1:0] dividend = '0;
  logic [N-1:0]   divisor = '0;
  logic           busy, done, error;
  logic [N-1:0]   quotient, remainder;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc++;

  rdiv_top #(.N(N)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .dividend_i  (dividend),
    .divisor_i   (divisor),
    .busy_o      (busy),
    .done_o      (done),
    .quotient_o  (quotient),
    .remainder_o (remainder),
    .error_o     (error)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    wait (cyc >= 190000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
    $finish;
  end

  // Pulse start for one edge, then count edges until done (0 for rejected operations).
  task automatic run_op(input int dvd, input int dvs, output int lat, output bit busy_first);
    @(negedge clk);
    start = 1'b1;
    dividend = (2*N)'(dvd);
    divisor = N'(dvs);
    @(negedge clk);
    start = 1'b0;
    busy_first = busy;
    lat = 0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic check_op(input int dvd, input int dvs, input string tag);
    int lat;
    bit bf;
    bit bad;
    int eq, er;
    bad = (dvs == 0) || ((dvd / dvs) > MAXQ);
    eq = bad ? MAXQ : dvd / dvs;
    er = bad ? 0 : dvd % dvs;
    run_op(dvd, dvs, lat, bf);
    check(error == bad, tag, "error", int'(error), int'(bad));
    check(int'(quotient) == eq, tag, "quotient", int'(quotient), eq);
    check(int'(remainder) == er, tag, "remainder", int'(remainder), er);
    check(lat == (bad ? 0 : N), "R6", "latency", lat, bad ? 0 : N);
    check(bf == !bad, "R6", "busy after start", int'(bf), int'(!bad));
  endtask

  initial begin
    int lat;
    bit bf;
    logic [N-1:0] q_hold, r_hold;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !error, "R1", "flags", int'({busy, done, error}), 0);
    check(quotient == '0 && remainder == '0, "R1", "results", int'({quotient, remainder}), 0);
    rst_n = 1'b1;

    // R2 worked example
    check_op(147, 11, "R2");

    // R8 start during a run is ignored
    @(negedge clk);
    start = 1'b1; dividend = 8'd147; divisor = 4'd11;
    @(negedge clk);
    dividend = 8'd200; divisor = 4'd3;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    check(quotient == 4'd13 && remainder == 4'd4 && !error, "R8", "result",
          int'({quotient, remainder}), int'({4'd13, 4'd4}));
    check(lat == N, "R8", "latency", lat, N);

    // R7 done is one cycle; R9 results held while idle
    q_hold = quotient; r_hold = remainder;
    @(negedge clk);
    check(!done, "R7", "done second cycle", int'(done), 0);
    dividend = 8'd5; divisor = 4'd0;
    repeat (5) @(negedge clk);
    check(quotient == q_hold && remainder == r_hold && !error, "R9", "held",
          int'({quotient, remainder}), int'({q_hold, r_hold}));

    // R4 zero divisor, R5 overflow boundary, R10 error cleared
    check_op(77, 0, "R4");
    check_op(16 * 9, 9, "R5");
    check_op(16 * 9 - 1, 9, "R10");
    check_op(255, 15, "R5");
    check_op(239, 15, "R3");

    // R2/R3/R4/R5 exhaustive sweep
    for (int d = 0; d < (1 << (2*N)); d++) begin
      for (int v = 0; v < (1 << N); v++) begin
        check_op(d, v, (v == 0) ? "R4" : (((d / v) > MAXQ) ? "R5" : "R2"));
      end
    end

    summary();
    $finish;
  end
endmodule